// File: doc/BRIEF.md
# Resettable Sample Demultiplexer with Phase-Aligned Reset Output

This block sits behind a fast 8-bit sampler and spreads the stream of accepted samples over two output words, a primary and an auxiliary one. In pass-through mode every sample goes to the primary word. In the two-way mode, samples alternate between the two words. In the four-way mode, each word carries a pair of samples. A data-ready flag marks each cycle in which the output words carry a newly completed group, so the flag runs at the sample rate divided by the group size.

Everything runs on the one sample clock. A sample counts only in cycles where its valid input is high. The group counter has no phase of its own at start-up. The synchronous reset input forces it to zero. Several instances released from reset in the same cycle therefore place matching samples in matching lanes. The reset is also passed through a delay chain whose length equals the data latency. The reset output then falls in the same cycle that the output words begin to carry data sampled after release, so further stages down the line can be brought into step.

Top module: `demux_clkgen`

## Requirements
- R1: The group size is chosen by two static inputs. `demux_en`=0 selects size 1, whatever `div_sel` is. `demux_en`=1 with `div_sel`=0 selects size 2. `demux_en`=1 with `div_sel`=1 selects size 4. The inputs change only while `rst_in` is high.
- R2: With size 1, each accepted sample s appears as `pri_data`={8'h00,s} with `dready` high, and `aux_data` keeps its value.
- R3: With size 2, accepted samples are numbered from 0 after reset. An even sample s0 and the odd sample s1 after it appear together as `pri_data`={8'h00,s0} and `aux_data`={8'h00,s1}.
- R4: With size 4, four consecutive accepted samples s0..s3 appear as `pri_data`={s1,s0} and `aux_data`={s3,s2}. The earlier sample of each pair is in the low byte.
- R5: A cycle with `samp_valid` low neither advances the group counter nor stores its data.
- R6: A group whose last sample is presented in cycle c appears on the output words, with `dready` high, in cycle c+LAT. LAT defaults to 4.
- R7: While `rst_in` is high the group counter is held at zero, and `dready` goes low and stays low once LAT cycles have passed. The first sample accepted after release is sample 0 of a new group, and a partly filled group from before the reset is dropped.
- R8: `rst_out` equals `rst_in` delayed by exactly LAT cycles.
- R9: `pri_data` and `aux_data` change only in cycles where `dready` is high. `dready` and `rst_out` are never high in the same cycle. In sizes 2 and 4, `dready` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, rising edge active |
| rst_in | input | 1 | Synchronous demux reset, active high |
| demux_en | input | 1 | Demultiplexing enable (static) |
| div_sel | input | 1 | Two-way / four-way select (static) |
| samp_valid | input | 1 | Sample on `samp_data` is valid this cycle |
| samp_data | input | 8 | Input sample |
| pri_data | output | 16 | Primary output word |
| aux_data | output | 16 | Auxiliary output word |
| dready | output | 1 | High in the cycles in which the output words carry a new group |
| rst_out | output | 1 | Reset delayed to line up with the output data |

## Verification
All three group sizes are driven with unbroken runs of samples. This shows lane order and byte packing, and it shows that each group comes out exactly LAT cycles after its last sample. The same modes are then driven with gaps in the valid input. A design that counted raw clocks instead of accepted samples would place bytes in the wrong lanes. Resets are issued part-way through a two-way group and part-way through a four-way group, to show that the counter restarts at phase zero rather than carrying on. The fall of the reset output is timed against the release of the reset input in every mode.

// File: rtl/demux_pkg.sv
package demux_pkg;

   typedef enum logic [1:0] {
      MODE_DIV1 = 2'd0,
      MODE_DIV2 = 2'd1,
      MODE_DIV4 = 2'd2
   } demux_mode_e;

   // R1: static mode decode
   function automatic demux_mode_e decode_mode(input logic en, input logic sel);
      if (!en)
         return MODE_DIV1;
      else if (!sel)
         return MODE_DIV2;
      else
         return MODE_DIV4;
   endfunction

endpackage

// File: rtl/demux_delay.sv
module demux_delay #(
   parameter int W = 1,
   parameter int D = 1
) (
   input  logic         clk,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   generate
      if (D == 0) begin : g_thru
         assign dout = din;
      end else begin : g_pipe
         logic [W-1:0] stg [D];
         always_ff @(posedge clk) begin
            stg[0] <= din;
         end
         for (genvar i = 1; i < D; i++) begin : g_stage
            always_ff @(posedge clk) begin
               stg[i] <= stg[i-1];
            end
         end
         assign dout = stg[D-1];
      end
   endgenerate

endmodule

// File: rtl/demux_lane_asm.sv
module demux_lane_asm
   import demux_pkg::*;
#(
   parameter int SW = 8,
   localparam int PW = 2 * SW
) (
   input  logic              clk,
   input  logic              rst,
   input  demux_mode_e       mode,
   input  logic              in_valid,
   input  logic [SW-1:0]     in_data,
   output logic              strobe,
   output logic [PW-1:0]     pri,
   output logic [PW-1:0]     aux
);

   localparam logic [SW-1:0] ZB = '0;

   logic [1:0]    cnt;
   logic [SW-1:0] hold0, hold1, hold2;
   logic [1:0]    last;

   always_comb begin
      unique case (mode)
         MODE_DIV2: last = 2'd1;
         MODE_DIV4: last = 2'd3;
         default:   last = 2'd0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt    <= '0;
         strobe <= 1'b0;
      end else begin
         strobe <= 1'b0;
         if (in_valid) begin
            if (cnt == last) begin
               cnt    <= '0;
               strobe <= 1'b1;
               unique case (mode)
                  MODE_DIV2: begin
                     pri <= {ZB, hold0};
                     aux <= {ZB, in_data};
                  end
                  MODE_DIV4: begin
                     pri <= {hold1, hold0};
                     aux <= {in_data, hold2};
                  end
                  default: begin
                     pri <= {ZB, in_data};
                  end
               endcase
            end else begin
               cnt <= cnt + 2'd1;
               unique case (cnt)
                  2'd0:    hold0 <= in_data;
                  2'd1:    hold1 <= in_data;
                  default: hold2 <= in_data;
               endcase
            end
         end
      end
   end

endmodule

// File: rtl/demux_clkgen.sv
module demux_clkgen
   import demux_pkg::*;
#(
   parameter int SW  = 8,
   parameter int LAT = 4,
   localparam int PW = 2 * SW,
   localparam int BW = 1 + 2 * PW
) (
   input  logic          clk,
   input  logic          rst_in,
   input  logic          demux_en,
   input  logic          div_sel,
   input  logic          samp_valid,
   input  logic [SW-1:0] samp_data,
   output logic [PW-1:0] pri_data,
   output logic [PW-1:0] aux_data,
   output logic          dready,
   output logic          rst_out
);

   generate
      if (LAT < 1) begin : g_bad_lat
         $error("demux_clkgen: LAT must be at least 1");
      end
      if (SW < 1) begin : g_bad_sw
         $error("demux_clkgen: SW must be at least 1");
      end
   endgenerate

   demux_mode_e   mode;
   logic          a_strobe;
   logic [PW-1:0] a_pri, a_aux;
   logic [BW-1:0] bundle_in, bundle_out;

   assign mode = decode_mode(demux_en, div_sel);

   demux_lane_asm #(.SW(SW)) u_asm (
      .clk      (clk),
      .rst      (rst_in),
      .mode     (mode),
      .in_valid (samp_valid),
      .in_data  (samp_data),
      .strobe   (a_strobe),
      .pri      (a_pri),
      .aux      (a_aux)
   );

   assign bundle_in = {a_strobe, a_pri, a_aux};

   demux_delay #(.W(BW), .D(LAT - 1)) u_data_dly (
      .clk  (clk),
      .din  (bundle_in),
      .dout (bundle_out)
   );

   assign {dready, pri_data, aux_data} = bundle_out;

   demux_delay #(.W(1), .D(LAT)) u_rst_dly (
      .clk  (clk),
      .din  (rst_in),
      .dout (rst_out)
   );

endmodule

// File: rtl/demux_clkgen_chk.sv
module demux_clkgen_chk #(
   parameter int PW = 16
) (
   input logic          clk,
   input logic          rst_in,
   input logic          demux_en,
   input logic          dready,
   input logic          rst_out,
   input logic [PW-1:0] pri_data,
   input logic [PW-1:0] aux_data
);

   assert_no_ready_in_reset_R9: assert property (@(posedge clk) disable iff (rst_in)
      !(dready && rst_out));

   assert_data_moves_with_ready_R9: assert property (@(posedge clk) disable iff (rst_in)
      !dready |-> ($stable(pri_data) && $stable(aux_data)));

   assert_no_back_to_back_R9: assert property (@(posedge clk) disable iff (rst_in)
      (demux_en && dready) |=> !dready);

   assert_aux_idle_div1_R2: assert property (@(posedge clk) disable iff (rst_in)
      !demux_en |=> $stable(aux_data));

endmodule

bind demux_clkgen demux_clkgen_chk #(.PW(PW)) u_chk (
   .clk      (clk),
   .rst_in   (rst_in),
   .demux_en (demux_en),
   .dready   (dready),
   .rst_out  (rst_out),
   .pri_data (pri_data),
   .aux_data (aux_data)
);

// File: tb/tb_demux_clkgen.sv
module tb_demux_clkgen;

   localparam int LAT = 4;

   logic        clk = 1'b0;
   logic        rst_in = 1'b1;
   logic        demux_en = 1'b0;
   logic        div_sel = 1'b0;
   logic        samp_valid = 1'b0;
   logic [7:0]  samp_data = 8'h00;
   logic [15:0] pri_data, aux_data;
   logic        dready, rst_out;

   always #2 clk = ~clk;

   demux_clkgen #(.SW(8), .LAT(LAT)) dut (
      .clk        (clk),
      .rst_in     (rst_in),
      .demux_en   (demux_en),
      .div_sel    (div_sel),
      .samp_valid (samp_valid),
      .samp_data  (samp_data),
      .pri_data   (pri_data),
      .aux_data   (aux_data),
      .dready     (dready),
      .rst_out    (rst_out)
   );

   typedef struct {
      int          due;
      logic [15:0] p;
      logic [15:0] a;
      bit          keep_aux;
      string       tag;
   } item_t;

   item_t       q[$];
   int          cyc = 0;
   int          n_chk = 0;
   int          n_fail = 0;
   int          rel_due = -100;
   bit          mon_on = 0;
   int          bmode = 1;
   int          bcnt = 0;
   logic [7:0]  bh [3];
   logic [15:0] prev_aux = '0;
   string       extra = "";

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string tag, input logic [15:0] act,
                        input logic [15:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic push(input logic [15:0] p, input logic [15:0] a, input bit ka);
      item_t it;
      it.due = cyc + LAT;
      it.p = p;
      it.a = a;
      it.keep_aux = ka;
      it.tag = {(bmode == 1) ? "R1 R2" : (bmode == 2) ? "R1 R3" : "R1 R4", extra};
      q.push_back(it);
   endtask

   // driver: presents one input cycle and records the expected group
   task automatic send(input bit v, input logic [7:0] d);
      @(negedge clk);
      samp_valid = v;
      samp_data = d;
      if (v) begin
         if (bmode == 1) begin
            push({8'h00, d}, 16'h0, 1'b1);
         end else if (bmode == 2) begin
            if (bcnt == 0) begin
               bh[0] = d;
               bcnt = 1;
            end else begin
               push({8'h00, bh[0]}, {8'h00, d}, 1'b0);
               bcnt = 0;
            end
         end else begin
            if (bcnt < 3) begin
               bh[bcnt] = d;
               bcnt++;
            end else begin
               push({bh[1], bh[0]}, {d, bh[2]}, 1'b0);
               bcnt = 0;
            end
         end
      end
   endtask

   task automatic do_reset(input bit en, input bit sel);
      @(negedge clk);
      rst_in = 1'b1;
      samp_valid = 1'b0;
      demux_en = en;
      div_sel = sel;
      bmode = !en ? 1 : (!sel ? 2 : 4);
      bcnt = 0;
      repeat (LAT + 4) @(negedge clk);
      check(rst_out === 1'b1, "R8 rst_out high in reset", {15'h0, rst_out}, 16'h1);
      check(dready === 1'b0, "R7 dready low in reset", {15'h0, dready}, 16'h0);
      mon_on = 1;
      rst_in = 1'b0;
      rel_due = cyc + LAT;
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (mon_on) begin
         if (dready === 1'b1) begin
            if (q.size() == 0) begin
               check(1'b0, "R9 dready with no pending group", {15'h0, dready}, 16'h0);
            end else begin
               item_t it;
               it = q.pop_front();
               check(it.due == cyc, {"R6 latency ", it.tag}, 16'(cyc), 16'(it.due));
               check(pri_data === it.p, {it.tag, " pri_data"}, pri_data, it.p);
               if (it.keep_aux)
                  check(aux_data === prev_aux, {it.tag, " aux_data held"}, aux_data, prev_aux);
               else
                  check(aux_data === it.a, {it.tag, " aux_data"}, aux_data, it.a);
            end
         end else if (q.size() != 0 && q[0].due <= cyc) begin
            check(1'b0, {"R6 missing dready ", q[0].tag}, 16'(cyc), 16'(q[0].due));
            void'(q.pop_front());
         end
         if (cyc == rel_due - 1)
            check(rst_out === 1'b1, "R8 rst_out before delay ends", {15'h0, rst_out}, 16'h1);
         if (cyc == rel_due)
            check(rst_out === 1'b0, "R8 rst_out falls after LAT", {15'h0, rst_out}, 16'h0);
      end
      prev_aux = aux_data;
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      // R1 R2: pass-through, continuous then with gaps (R5)
      do_reset(1'b0, 1'b1);
      for (int i = 0; i < 6; i++) send(1'b1, 8'h10 + 8'(i));
      extra = " R5";
      send(1'b0, 8'hEE);
      send(1'b1, 8'h21);
      send(1'b0, 8'hEF);
      send(1'b0, 8'hEF);
      send(1'b1, 8'h22);
      send(1'b0, 8'h00);
      extra = "";
      // R3: two-way, continuous
      do_reset(1'b1, 1'b0);
      for (int i = 0; i < 8; i++) send(1'b1, 8'h30 + 8'(i));
      // R5: two-way with gaps inside and between groups
      extra = " R5";
      send(1'b1, 8'hA0);
      send(1'b0, 8'h55);
      send(1'b1, 8'hA1);
      send(1'b1, 8'hA2);
      send(1'b0, 8'h66);
      send(1'b0, 8'h67);
      send(1'b1, 8'hA3);
      send(1'b0, 8'h00);
      extra = "";
      // R7: reset part-way through a two-way group
      send(1'b1, 8'hDD);
      extra = " R7";
      do_reset(1'b1, 1'b0);
      send(1'b1, 8'hB0);
      send(1'b1, 8'hB1);
      send(1'b0, 8'h00);
      extra = "";
      // R4: four-way, continuous
      do_reset(1'b1, 1'b1);
      for (int i = 0; i < 12; i++) send(1'b1, 8'h40 + 8'(i));
      // R5: four-way with scattered gaps
      extra = " R5";
      for (int i = 0; i < 12; i++) send((i % 3) != 1, 8'h80 + 8'(i));
      send(1'b0, 8'h00);
      extra = "";
      // R7: reset after two samples of a four-way group
      send(1'b1, 8'hC0);
      send(1'b1, 8'hC1);
      extra = " R7";
      do_reset(1'b1, 1'b1);
      for (int i = 0; i < 4; i++) send(1'b1, 8'hE0 + 8'(i));
      send(1'b0, 8'h00);
      extra = "";
      // R1: demux disabled ignores div_sel
      do_reset(1'b0, 1'b0);
      send(1'b1, 8'h5A);
      send(1'b1, 8'hA5);
      send(1'b0, 8'h00);
      repeat (LAT + 4) @(negedge clk);
      check(q.size() == 0, "R6 all groups delivered", 16'(q.size()), 16'h0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule